// File: doc/BRIEF.md
# Dual Reloading Interval Timers

Two independent down-counting timers advance on a shared `tick` strobe, each with its own level interrupt. Timer A counts down from a programmable reload value in steps of two. It runs only while its reload value and current count are both positive and a gate bit in a software mask register is set. When its count reaches zero or goes below, an interrupt is latched. Any access to A's status register clears that interrupt and restarts the count from the reload value.

Timer B is a free-running periodic timer. While its period register is nonzero, it subtracts five on each tick. When the result falls below one, it reloads from the period and latches its interrupt. A dedicated `ack_b` pulse clears that interrupt.

Software reaches four word registers through a single-cycle access port: read data is combinational and writes take effect at the clock edge. The address codes are 0 for A's reload, 1 for A's status, 2 for the mask, and 3 for B's period.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both interrupt outputs are low, and the reload, status, mask and period registers all read 0.
- R2: Writing address 0 stores the value as A's reload and also loads it into A's count. Reading address 0 returns the reload value.
- R3: On a tick where the reload value is positive, A's count is positive, and mask bit 1 is set, A's count drops by exactly 2. In every other cycle without a register access, A's count holds.
- R4: A's interrupt latches in the cycle a decrement leaves the count at zero or below. It stays latched until address 1 is accessed.
- R5: An access to address 1 clears A's interrupt, and a read returns the count held before the access. Whether the access is a read or a write, the count then equals the reload value, so written data is discarded. An access in the same cycle as a tick takes precedence over the decrement.
- R6: Address 2 reads back the last value written. `irq_a` is A's latched interrupt ANDed with mask bit 1, so a mask write re-evaluates the output.
- R7: While the period is nonzero, each tick subtracts 5 from B's count. When the result is below 1, the count reloads from the period and B's interrupt latches. After reset, B's count is 0, so the first tick with a nonzero period fires at once. Address 3 reads back the period.
- R8: `ack_b` clears B's interrupt. If B fires in the same cycle as `ack_b`, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared timebase strobe |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 2 | Register select (0 reload, 1 status, 2 mask, 3 period) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ack_b | input | 1 | Clears timer B interrupt |
| irq_a | output | 1 | Timer A interrupt level |
| irq_b | output | 1 | Timer B interrupt level |

## Verification
The bench targets the boundaries of each timer.

- Timer A landing exactly on zero: a design that compared with "less than" would never interrupt on an even reload.
- A status write carrying data: a design that kept the written count instead of the reload would drift.
- A status access in the same cycle as a tick: a design that let the decrement win would leave the count two short.
- Mask bit 1 toggled while A's interrupt is latched: an unmasked output would stay high.
- `ack_b` in the same cycle as a B wrap: a design that favoured the acknowledge would drop an event.
- A period smaller than the step size: a design that tested for zero instead of below one would run past zero.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int W        = 32,
  parameter int AW       = 2,
  parameter int A_STEP   = 2,
  parameter int B_STEP   = 5,
  parameter int GATE_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ack_b,
  output logic          irq_a,
  output logic          irq_b
);
  localparam logic [AW-1:0] ADR_RELOAD = AW'(0);
  localparam logic [AW-1:0] ADR_STATUS = AW'(1);
  localparam logic [AW-1:0] ADR_MASK   = AW'(2);
  localparam logic [AW-1:0] ADR_PERIOD = AW'(3);
  localparam logic signed [W-1:0] STEP_A = W'(A_STEP);
  localparam logic signed [W-1:0] STEP_B = W'(B_STEP);

  logic signed [W-1:0] reload_q, cnt_a_q, period_q, cnt_b_q;
  logic        [W-1:0] mask_q;
  logic                pend_a_q, pend_b_q;

  wire wr_reload = reg_en && reg_we && reg_addr == ADR_RELOAD;
  wire acc_stat  = reg_en && reg_addr == ADR_STATUS;
  wire wr_mask   = reg_en && reg_we && reg_addr == ADR_MASK;
  wire wr_period = reg_en && reg_we && reg_addr == ADR_PERIOD;

  wire run_a = tick && reload_q > 0 && cnt_a_q > 0 && mask_q[GATE_BIT];
  wire signed [W-1:0] dec_a = cnt_a_q - STEP_A;
  wire run_b = tick && period_q != '0;
  wire signed [W-1:0] dec_b = cnt_b_q - STEP_B;
  wire wrap_b = run_b && dec_b < 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_a_q  <= '0;
      pend_a_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (wr_reload) begin
        reload_q <= reg_wdata;
        cnt_a_q  <= reg_wdata;
      end else if (acc_stat) begin
        cnt_a_q  <= reload_q;
        pend_a_q <= 1'b0;
      end else if (run_a) begin
        cnt_a_q <= dec_a;
        if (dec_a <= 0) pend_a_q <= 1'b1;
      end
      if (wr_mask) mask_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_b_q  <= '0;
      pend_b_q <= 1'b0;
    end else begin
      if (wr_period) period_q <= reg_wdata;
      if (wrap_b) begin
        cnt_b_q  <= period_q;
        pend_b_q <= 1'b1;
      end else begin
        if (run_b) cnt_b_q <= dec_b;
        if (ack_b) pend_b_q <= 1'b0;
      end
    end
  end

  assign irq_a = pend_a_q && mask_q[GATE_BIT];
  assign irq_b = pend_b_q;

  always_comb begin
    case (reg_addr)
      ADR_RELOAD: reg_rdata = reload_q;
      ADR_STATUS: reg_rdata = cnt_a_q;
      ADR_MASK:   reg_rdata = mask_q;
      default:    reg_rdata = period_q;
    endcase
  end

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stat && !wr_reload |=> !pend_a_q && cnt_a_q == $past(reload_q)); // R5
  AST_A_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_a && !reg_en |=> cnt_a_q == $past(cnt_a_q) - STEP_A); // R3
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !reg_en |=> $stable(cnt_a_q)); // R3
  AST_A_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend_a_q && !acc_stat |=> pend_a_q); // R4
  AST_B_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_q == '0 && !wr_period |=> $stable(cnt_b_q)); // R7
  AST_B_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_b && !run_b |=> !pend_b_q); // R8
  always_comb if (rst_n) AST_A_GATED: assert (!irq_a || mask_q[GATE_BIT]); // R6
endmodule

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/1ps
module test_dual_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_en = 1'b0, reg_we = 1'b0, ack_b = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_a, irq_b;
  int total = 0, bad = 0;
  int m_rel, m_ca, m_per, m_cb;
  logic [31:0] m_mask;
  bit m_pa, m_pb;

  always #2.5 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk, .rst_n, .tick, .reg_en, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .ack_b, .irq_a, .irq_b);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_rel;
      2'd1: return m_ca;
      2'd2: return m_mask;
      default: return m_per;
    endcase
  endfunction

  task automatic model_step(bit t, bit en, bit we, logic [1:0] a, logic [31:0] wd, bit ack);
    int d;
    int per_old = m_per;
    bit wrap = 1'b0;
    if (en && we && a == 2'd0) begin m_rel = wd; m_ca = wd; end
    else if (en && a == 2'd1) begin m_pa = 1'b0; m_ca = m_rel; end
    else if (t && m_rel > 0 && m_ca > 0 && m_mask[1]) begin
      m_ca = m_ca - 2;
      if (m_ca <= 0) m_pa = 1'b1;
    end
    if (en && we && a == 2'd2) m_mask = wd;
    if (en && we && a == 2'd3) m_per = wd;
    if (t && per_old != 0) begin
      d = m_cb - 5;
      if (d < 1) begin m_cb = per_old; m_pb = 1'b1; wrap = 1'b1; end
      else m_cb = d;
    end
    if (ack && !wrap) m_pb = 1'b0;
  endtask

  // Drives one cycle, compares outputs against the model, then advances both.
  task automatic cyc(bit t, bit en, bit we, logic [1:0] a, logic [31:0] wd, bit ack);
    tick = t; reg_en = en; reg_we = we; reg_addr = a; reg_wdata = wd; ack_b = ack;
    #1;
    chk("R6 irq_a", irq_a, m_pa && m_mask[1]);
    chk("R8 irq_b", irq_b, m_pb);
    if (en && !we) chk("R2/R5 rdata", reg_rdata, model_read(a));
    @(posedge clk);
    model_step(t, en, we, a, wd, ack);
    @(negedge clk);
    tick = 0; reg_en = 0; reg_we = 0; ack_b = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rel = 0; m_ca = 0; m_per = 0; m_cb = 0; m_mask = 0; m_pa = 0; m_pb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_a", irq_a, 0); chk("R1 irq_b", irq_b, 0);
    for (int a = 0; a < 4; a++) rd(2'(a), "R1 reg", 0);

    // R2 reload write and read back
    cyc(0,1,1,2'd0,32'd6,0);
    rd(2'd0, "R2 reload", 6); rd(2'd1, "R2 count", 6);
    // R3 gate closed: mask bit1 clear, tick does nothing
    cyc(1,0,0,2'd0,0,0);
    rd(2'd1, "R3 gated hold", 6);
    cyc(0,1,1,2'd2,32'h2,0);
    rd(2'd2, "R6 mask readback", 2);
    // R3/R4 6 -> 4 -> 2 -> 0, fires exactly at zero
    cyc(1,0,0,2'd0,0,0); rd(2'd1, "R3 step", 4);
    cyc(1,0,0,2'd0,0,0); cyc(1,0,0,2'd0,0,0);
    rd(2'd1, "R4 count zero", 0); chk("R4 irq_a at zero", irq_a, 1);
    cyc(1,0,0,2'd0,0,0); rd(2'd1, "R3 stops at zero", 0);
    // R6 masking hides and restores the latched interrupt
    cyc(0,1,1,2'd2,32'h0,0); chk("R6 masked", irq_a, 0);
    cyc(0,1,1,2'd2,32'h2,0); chk("R6 unmasked", irq_a, 1);
    // R5 status write discards data, reloads, clears
    cyc(0,1,1,2'd1,32'd99,0);
    rd(2'd1, "R5 reload after write", 6); chk("R5 irq cleared", irq_a, 0);
    // R5 status read concurrent with tick: access wins
    cyc(1,1,0,2'd1,0,0); rd(2'd1, "R5 access beats tick", 6);

    // R7 period 3 below step: fires on each tick
    cyc(0,1,1,2'd3,32'd3,0); rd(2'd3, "R7 period readback", 3);
    cyc(1,0,0,2'd0,0,0); chk("R7 first tick fires", irq_b, 1);
    cyc(0,0,0,2'd0,0,1); chk("R8 ack clears", irq_b, 0);
    // R8 ack coincident with wrap keeps interrupt
    cyc(1,0,0,2'd0,0,1); chk("R8 wrap beats ack", irq_b, 1);
    // R7 period 12: 12 ->7 ->2 -> wrap
    cyc(0,1,1,2'd3,32'd12,1);
    cyc(1,0,0,2'd0,0,0); cyc(0,0,0,2'd0,0,1);
    cyc(1,0,0,2'd0,0,0); chk("R7 no fire at 7", irq_b, 0);
    cyc(1,0,0,2'd0,0,0); chk("R7 no fire at 2", irq_b, 0);
    cyc(1,0,0,2'd0,0,0); chk("R7 fire below 1", irq_b, 1);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      bit t = ($urandom % 2) == 0;
      bit en = ($urandom % 4) == 0;
      bit we = ($urandom % 2) == 0;
      logic [1:0] a = 2'($urandom % 4);
      logic [31:0] wd = (a == 2'd2) ? 32'($urandom % 4) : 32'($urandom % 40);
      bit ack = ($urandom % 8) == 0;
      cyc(t, en, we, a, wd, ack);
      if (n % 16 == 0) for (int r = 0; r < 4; r++) rd(2'(r), "R2/R6/R7 model", model_read(2'(r)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule